// File: doc/BRIEF.md
# Reset Cause Recorder with Guarded Software Reset

This block keeps a sticky record of which reset event the chip last went through, and it lets software ask for a reset of its own. Each reset source delivers a one-cycle pulse: power-on, external pin, brown-out, watchdog, debug/programming port, and software. Every pulse raises its own flag in a status register. Software reads that register over a small byte-wide register bus and clears flags by writing ones to them.

A second register holds a single request bit. While that bit is set, the block drives a software-reset request towards the reset controller. The bit can only be written during a short window that opens after a separate unlock pulse. The bit drops by itself when any reset event arrives, so the request never outlives the reset it caused.

A power-on event is special: it wipes every other cause flag and leaves only its own flag set. All other reset events leave the flags already recorded in place.

Top module: `rst_cause_unit`

## Requirements
- R1: When `rst_n` is held low, all cause flags and the request bit go to zero at the next clock edge, and `sw_rst_req_o` is low.
- R2: The status register sits at address 0 with this layout: bit5 software, bit4 debug port, bit3 watchdog, bit2 brown-out, bit1 external, bit0 power-on. Bits 7:6 read as zero. A pulse on a source input sets its flag.
- R3: When several non-power-on events pulse in the same cycle, all of their flags are set together.
- R4: Writing address 0 clears each flag whose data bit is one and leaves flags with a zero data bit unchanged. If an event for a flag arrives in the same cycle as the clear of that flag, the flag stays set.
- R5: A power-on pulse leaves the status at exactly 0x01, including when other events pulse in the same cycle.
- R6: Every event other than power-on leaves the flags that were already set unchanged.
- R7: The control register sits at address 1. Bit0 is the software-reset request and bits 7:1 read as zero. `sw_rst_req_o` follows bit0.
- R8: A pulse on `unlock_i` opens a write window. A control write is honoured only on the 4 clock edges that follow the unlock edge. A control write outside the window, including one in the same cycle as the unlock, is ignored.
- R9: Any reset event pulse clears the request bit, and it wins over a control write in the same cycle.
- R10: Reads have one cycle of latency: `rd_data_o` shows, one edge after the address is presented, the register value from before that edge. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| ev_por_i | input | 1 | Power-on event pulse |
| ev_ext_i | input | 1 | External pin reset event pulse |
| ev_bod_i | input | 1 | Brown-out event pulse |
| ev_wdt_i | input | 1 | Watchdog event pulse |
| ev_dbg_i | input | 1 | Debug/programming port reset event pulse |
| ev_sw_i | input | 1 | Software reset event pulse |
| unlock_i | input | 1 | Single-cycle pulse that opens the protected write window |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| sw_rst_req_o | output | 1 | Software reset request |

## Verification
The assertions assume that event and unlock inputs are synchronous single-cycle pulses. They also assume these inputs stay low while `rst_n` is asserted, so that no property starts from a reset-period antecedent. The stimulus drives every input on the falling edge and returns it to zero after one cycle. It holds all inputs idle during reset. It places unlock, write and event pulses on exact cycle offsets, so that the window edges and the collisions between a write and an event land on known clock edges.

// File: rtl/rstc_pkg.sv
// Package: shared cause indices and vector type for the reset cause recorder.
// Assumes: cause bit positions are fixed because software decodes them.
package rstc_pkg;
    localparam int NUM_CAUSES = 6;
    localparam int C_POR = 0;
    localparam int C_EXT = 1;
    localparam int C_BOD = 2;
    localparam int C_WDT = 3;
    localparam int C_DBG = 4;
    localparam int C_SW  = 5;
    typedef logic [NUM_CAUSES-1:0] cause_vec_t;
endpackage

// File: rtl/rstc_cause_flags.sv
// Module: sticky cause flags with write-one-to-clear and power-on override.
// Assumes: ev_i bits are single-cycle pulses; clr_en_i qualifies clr_mask_i.
module rstc_cause_flags
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cause_vec_t ev_i,
    input  logic       clr_en_i,
    input  cause_vec_t clr_mask_i,
    output cause_vec_t flags_o
);
    cause_vec_t flags_q;
    cause_vec_t flags_d;

    // Next state: clear the requested bits, then set on events; power-on overrides all.
    always_comb begin
        flags_d = flags_q;
        if (clr_en_i) begin
            flags_d = flags_d & ~clr_mask_i;
        end
        flags_d = flags_d | ev_i;
        if (ev_i[C_POR]) begin
            flags_d        = '0;
            flags_d[C_POR] = 1'b1;
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    assert_por_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i[C_POR] |=> (flags_q == cause_vec_t'(1)));

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i[C_POR] && (ev_i != '0)) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && (ev_i == '0)) |=> ((flags_q & $past(clr_mask_i)) == '0));

    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i[C_POR] && !clr_en_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/rstc_unlock_window.sv
// Module: protected-change window timer opened by a single-cycle unlock pulse.
// Assumes: WINDOW_CYCLES >= 1; a new unlock reloads the full window.
module rstc_unlock_window #(
    parameter int WINDOW_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_i,
    output logic open_o
);
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Countdown: load on unlock, otherwise decrement towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (unlock_i)      cnt_q <= CNT_MAX;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign open_o = (cnt_q != '0);

    assert_open_after_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_i |=> open_o);

    assert_stays_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock_i && !open_o) |=> !open_o);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
endmodule

// File: rtl/rstc_swreset_ctrl.sv
// Module: self-clearing software reset request bit behind the unlock window.
// Assumes: any_ev_i is high in the cycle any reset event pulses.
module rstc_swreset_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wr_bit_i,
    input  logic open_i,
    input  logic any_ev_i,
    output logic swrst_o
);
    logic swrst_q;

    // Request bit: events clear it first, guarded writes load it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)              swrst_q <= 1'b0;
        else if (any_ev_i)       swrst_q <= 1'b0;
        else if (wr_i && open_i) swrst_q <= wr_bit_i;
    end

    assign swrst_o = swrst_q;

    assert_event_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_ev_i |=> !swrst_q);

    assert_locked_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev_i && !(wr_i && open_i)) |=> $stable(swrst_q));

    assert_open_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && open_i && !any_ev_i) |=> (swrst_q == $past(wr_bit_i)));
endmodule

// File: rtl/rst_cause_unit.sv
// Module: top of the reset cause recorder; decodes the register bus and
// registers the read data. Assumes: byte-wide data bus, event pulses synchronous to clk.
module rst_cause_unit
    import rstc_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 2,
    parameter int STATUS_ADDR   = 0,
    parameter int CTRL_ADDR     = 1,
    parameter int WINDOW_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_por_i,
    input  logic              ev_ext_i,
    input  logic              ev_bod_i,
    input  logic              ev_wdt_i,
    input  logic              ev_dbg_i,
    input  logic              ev_sw_i,
    input  logic              unlock_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              sw_rst_req_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

    cause_vec_t        ev_vec;
    cause_vec_t        flags;
    logic              win_open;
    logic              swrst;
    logic              hit_stat;
    logic              hit_ctrl;
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;

    // Gather the source pulses into one vector in status bit order.
    always_comb begin
        ev_vec        = '0;
        ev_vec[C_POR] = ev_por_i;
        ev_vec[C_EXT] = ev_ext_i;
        ev_vec[C_BOD] = ev_bod_i;
        ev_vec[C_WDT] = ev_wdt_i;
        ev_vec[C_DBG] = ev_dbg_i;
        ev_vec[C_SW]  = ev_sw_i;
    end

    assign hit_stat = (addr_i == A_STAT);
    assign hit_ctrl = (addr_i == A_CTRL);

    rstc_cause_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_vec),
        .clr_en_i   (wr_en_i && hit_stat),
        .clr_mask_i (wr_data_i[NUM_CAUSES-1:0]),
        .flags_o    (flags)
    );

    rstc_unlock_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlock_i (unlock_i),
        .open_o   (win_open)
    );

    rstc_swreset_ctrl u_swrst (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en_i && hit_ctrl),
        .wr_bit_i (wr_data_i[0]),
        .open_i   (win_open),
        .any_ev_i (ev_vec != '0),
        .swrst_o  (swrst)
    );

    // Read mux: reserved bits and unmapped addresses return zero.
    always_comb begin
        rd_d = '0;
        if (hit_stat)      rd_d[NUM_CAUSES-1:0] = flags;
        else if (hit_ctrl) rd_d[0]              = swrst;
    end

    // Read data register giving one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_o    = rd_q;
    assign sw_rst_req_o = swrst;

    assert_stat_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_stat |=> (rd_data_o[DATA_W-1:NUM_CAUSES] == '0));

    assert_ctrl_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |=> (rd_data_o[DATA_W-1:1] == '0));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_stat && !hit_ctrl) |=> (rd_data_o == '0));

    assert_ctrl_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |=> (rd_data_o[0] == $past(sw_rst_req_o)));
endmodule

// File: tb/rst_cause_unit_tb_top.sv
module rst_cause_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ev = '0;
    logic       unlock = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sw_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_issue = 1'b0;
    logic       rd_issue_d = 1'b0;

    always #4 clk = ~clk;

    rst_cause_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_por_i     (ev[0]),
        .ev_ext_i     (ev[1]),
        .ev_bod_i     (ev[2]),
        .ev_wdt_i     (ev[3]),
        .ev_dbg_i     (ev[4]),
        .ev_sw_i      (ev[5]),
        .unlock_i     (unlock),
        .addr_i       (addr),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .rd_data_o    (rd_data),
        .sw_rst_req_o (sw_req)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge and removed at the next.
    task automatic drive(logic [5:0] v, logic unl, logic we, logic [1:0] a, logic [7:0] d);
        ev = v; unlock = unl; wr_en = we; addr = a; wr_data = d;
        @(negedge clk);
        ev = '0; unlock = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver side of the scoreboard: issue a read and queue its expected value.
    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        addr = a;
        rd_issue = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    always @(posedge clk) rd_issue_d <= rd_issue;

    // Monitor side: compare the registered read data with the queued value.
    always @(negedge clk) begin
        if (rd_issue_d) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", rd_data, 8'hxx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 request low in reset", {7'b0, sw_req}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, 8'h00, "R1 status after reset");
        rd(2'd1, 8'h00, "R1 control after reset");

        drive(6'h01, 0, 0, 2'd0, 8'h00);
        rd(2'd0, 8'h01, "R2 power-on flag");
        drive(6'h08, 0, 0, 2'd0, 8'h00);
        rd(2'd0, 8'h09, "R6 watchdog keeps power-on");
        drive(6'h06, 0, 0, 2'd0, 8'h00);
        rd(2'd0, 8'h0F, "R3 brown-out and external together");

        drive(6'h00, 0, 1, 2'd0, 8'h08);
        rd(2'd0, 8'h07, "R4 write one clears watchdog");
        drive(6'h00, 0, 1, 2'd0, 8'hC0);
        rd(2'd0, 8'h07, "R4 zero bits leave flags");
        drive(6'h02, 0, 1, 2'd0, 8'h02);
        rd(2'd0, 8'h07, "R4 event wins over clear");

        drive(6'h30, 0, 0, 2'd0, 8'h00);
        rd(2'd0, 8'h37, "R2 debug and software flags");
        drive(6'h09, 0, 0, 2'd0, 8'h00);
        rd(2'd0, 8'h01, "R5 power-on with watchdog");

        drive(6'h00, 0, 1, 2'd1, 8'h01);
        rd(2'd1, 8'h00, "R8 locked write ignored");
        check("R8 request after locked write", {7'b0, sw_req}, 8'h00);
        drive(6'h00, 1, 1, 2'd1, 8'h01);
        rd(2'd1, 8'h00, "R8 write with unlock ignored");

        drive(6'h00, 1, 0, 2'd0, 8'h00);
        idle(4);
        drive(6'h00, 0, 1, 2'd1, 8'h01);
        rd(2'd1, 8'h00, "R8 write after window ignored");

        drive(6'h00, 1, 0, 2'd0, 8'h00);
        idle(3);
        drive(6'h00, 0, 1, 2'd1, 8'hFF);
        check("R7 request follows bit", {7'b0, sw_req}, 8'h01);
        rd(2'd1, 8'h01, "R7 control reads bit0 only");

        drive(6'h20, 0, 0, 2'd0, 8'h00);
        check("R9 software event clears request", {7'b0, sw_req}, 8'h00);
        rd(2'd0, 8'h21, "R6 software flag added");

        drive(6'h00, 1, 0, 2'd0, 8'h00);
        drive(6'h00, 0, 1, 2'd1, 8'h01);
        check("R8 write inside window", {7'b0, sw_req}, 8'h01);
        drive(6'h04, 0, 0, 2'd0, 8'h00);
        check("R9 brown-out clears request", {7'b0, sw_req}, 8'h00);
        rd(2'd0, 8'h25, "R6 brown-out added");

        drive(6'h00, 1, 0, 2'd0, 8'h00);
        drive(6'h02, 0, 1, 2'd1, 8'h01);
        check("R9 event beats write", {7'b0, sw_req}, 8'h00);
        rd(2'd1, 8'h00, "R9 control stays clear");

        rd(2'd2, 8'h00, "R10 unmapped 2");
        rd(2'd3, 8'h00, "R10 unmapped 3");
        rd(2'd0, 8'h27, "R10 status latency");

        idle(3);
        check("R10 queue drained", 8'(exp_q.size()), 8'h00);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule